// File: doc/BRIEF.md
# Direct-Mapped Write-Through Cache Controller

This controller runs a small unified cache that sits between a pipelined CPU and a slow external memory. The cached data lives in the upper half of an on-chip word RAM. The controller owns the address, byte-enable and write-data muxing of that RAM. It keeps one tag and one valid bit per cached word, and it tells the CPU through three flags whether a lookup is under way, whether it hit, and whether the CPU has to stall.

A lookup takes two cycles. In the access cycle, the CPU's next-cycle address is decoded. If that address falls in the cacheable window, the RAM is read at that index, or written if the access is a store. In the following checking cycle, the CPU's current address is compared against the tag store. Stores always go on to external memory as well. A read that misses stalls the CPU until the external memory stops signalling busy. The returned word is then written into the cache, together with its tag.

Top module: `wt_cache_ctrl`

## Requirements
- R1: Every cycle with `ram_en_o` high, `ram_addr_o` has its top bit set (upper half of the RAM), and its low bits equal word-address bits 11:2. These bits come from the next address in an access cycle and from the current address in a fill cycle.
- R2: An address is cacheable only when byte-address bits 31:28 equal 4'h1 and bits 27:21 are all zero. Any other next address never raises `cache_access_o`.
- R3: `cache_access_o` is decided from `addr_next_i` in the same cycle. In that cycle `ram_en_o` is high and `ram_we_o` equals `byte_we_next_i`. `cache_checking_o` is high in exactly the next cycle. When neither an access nor a fill is in progress, `ram_en_o` is low and `ram_we_o` is 4'b0000.
- R4: `cache_hit_o` is high exactly when `cache_checking_o` is high and `cache_miss_o` is low.
- R5: A read (all byte enables zero in its access cycle) whose entry is invalid or holds another tag raises `cache_miss_o` in its checking cycle. `cache_miss_o` then stays high for as long as `mem_busy_i` is high.
- R6: In the first cycle after a miss in which `mem_busy_i` is low, the controller fills the entry. `cache_miss_o` is low, `ram_we_o` is 4'b1111, and `ram_wdata_o` equals `mem_rdata_i`. Outside fills, `ram_wdata_o` equals `cpu_wdata_i`.
- R7: After a fill, the next read of the same word hits.
- R8: Reset clears all valid bits at once. The first read of any address after reset misses.
- R9: A full-word store (byte enables 4'b1111) installs its tag, so a later read of that word hits.
- R10: A partial store that finds another tag leaves the entry invalid, so the next read of the old word misses. A partial store that finds its own tag keeps the entry valid.
- R11: No access is started in a cycle that has `cache_miss_o` high or that performs a fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_next_i | input | 30 | CPU word address for the next cycle (bits 31:2) |
| byte_we_next_i | input | 4 | CPU byte write enables for the next cycle |
| cpu_addr_i | input | 30 | CPU word address of the current cycle (bits 31:2) |
| cpu_wdata_i | input | 32 | CPU store data |
| mem_rdata_i | input | 32 | Word returned by external memory |
| mem_busy_i | input | 1 | External memory not ready |
| cache_access_o | output | 1 | Cache lookup starts this cycle |
| cache_checking_o | output | 1 | Tag comparison in this cycle |
| cache_miss_o | output | 1 | Read miss, CPU must stall |
| cache_hit_o | output | 1 | Checking cycle without miss |
| ram_en_o | output | 1 | Cache RAM enable |
| ram_addr_o | output | 11 | Cache RAM word address |
| ram_we_o | output | 4 | Cache RAM byte write enables |
| ram_wdata_o | output | 32 | Cache RAM write data |

## Verification
A wrong valid or tag entry shows up at the ports in the checking cycle of the next lookup of that index. It appears as a hit where a miss is due, or the reverse, at most two cycles after the address is presented. A state-machine slip shows up one cycle after the fault, as a missing or extra checking flag, a stall that ignores `mem_busy_i`, or a fill that writes the wrong index or data. A reference model tracks tags, valid bits and the lookup state, and the outputs are compared against it in every cycle.

// File: rtl/cache_pkg.sv
`timescale 1ns/1ps
package cache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHECK = 2'd1,
    ST_MISS  = 2'd2
  } cache_state_e;

  localparam logic [3:0] BE_FULL = 4'hF;
  localparam logic [3:0] BE_NONE = 4'h0;
endpackage

// File: rtl/cache_win_dec.sv
`timescale 1ns/1ps
module cache_win_dec #(
  parameter int          ADDR_W  = 32,
  parameter int          REG_LSB = 28,
  parameter logic [3:0]  REG_VAL = 4'h1,
  parameter int          WIN_LSB = 21
) (
  input  logic [ADDR_W-1:2] addr_i,
  output logic              in_win_o
);
  localparam int REG_W = ADDR_W - REG_LSB;

  logic region_ok, window_ok;
  assign region_ok = (addr_i[ADDR_W-1:REG_LSB] == REG_W'(REG_VAL));
  assign window_ok = (addr_i[REG_LSB-1:WIN_LSB] == '0);
  assign in_win_o  = region_ok && window_ok;
endmodule

// File: rtl/cache_tag_store.sv
`timescale 1ns/1ps
module cache_tag_store #(
  parameter int IDX_W = 10,
  parameter int TAG_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  input  logic [TAG_W-1:0] rd_tag_i,
  output logic             rd_hit_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [TAG_W-1:0] wr_tag_i,
  input  logic             wr_valid_i
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0] valid_q;
  logic [TAG_W-1:0] tag_q [DEPTH];

  // valid bits clear in one step on reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= '0;
    else if (wr_en_i) valid_q[wr_idx_i] <= wr_valid_i;
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) tag_q[wr_idx_i] <= wr_tag_i;
  end

  assign rd_hit_o = valid_q[rd_idx_i] && (tag_q[rd_idx_i] == rd_tag_i);

  // R7
  fill_then_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_valid_i) |=>
      ((rd_idx_i != $past(wr_idx_i)) || (rd_tag_i != $past(wr_tag_i)) || rd_hit_o));

  // R10
  invalidate_miss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_valid_i) |=> ((rd_idx_i != $past(wr_idx_i)) || !rd_hit_o));
endmodule

// File: rtl/cache_fsm.sv
`timescale 1ns/1ps
module cache_fsm
  import cache_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       next_win_i,
  input  logic [3:0] byte_we_next_i,
  input  logic       lookup_hit_i,
  input  logic       mem_busy_i,
  output logic       access_o,
  output logic       checking_o,
  output logic       miss_o,
  output logic       fill_o,
  output logic       tag_we_o,
  output logic       tag_valid_o
);
  cache_state_e state_q, state_d;
  logic [3:0]   acc_we_q;
  logic         is_read, is_full;

  assign is_read    = (acc_we_q == BE_NONE);
  assign is_full    = (acc_we_q == BE_FULL);
  assign checking_o = (state_q == ST_CHECK);
  assign miss_o     = (checking_o && is_read && !lookup_hit_i) ||
                      ((state_q == ST_MISS) && mem_busy_i);
  assign fill_o     = (state_q == ST_MISS) && !mem_busy_i;
  assign access_o   = next_win_i &&
                      ((state_q == ST_IDLE) || (checking_o && !miss_o));

  // write-through stores: full word installs, partial mismatch invalidates
  assign tag_we_o    = fill_o || (checking_o && !is_read && (is_full || !lookup_hit_i));
  assign tag_valid_o = fill_o || is_full;

  always_comb begin
    state_d = ST_IDLE;
    if (access_o) state_d = ST_CHECK;
    else if (miss_o) state_d = ST_MISS;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      acc_we_q <= BE_NONE;
    end else begin
      state_q <= state_d;
      if (access_o) acc_we_q <= byte_we_next_i;
    end
  end

  // R5
  miss_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (miss_o && mem_busy_i) |=> (state_q == ST_MISS));
endmodule

// File: rtl/wt_cache_ctrl.sv
`timescale 1ns/1ps
module wt_cache_ctrl
  import cache_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int RAM_AW  = 11,
  parameter int WIN_LSB = 21
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:2] addr_next_i,
  input  logic [3:0]        byte_we_next_i,
  input  logic [ADDR_W-1:2] cpu_addr_i,
  input  logic [31:0]       cpu_wdata_i,
  input  logic [31:0]       mem_rdata_i,
  input  logic              mem_busy_i,
  output logic              cache_access_o,
  output logic              cache_checking_o,
  output logic              cache_miss_o,
  output logic              cache_hit_o,
  output logic              ram_en_o,
  output logic [RAM_AW-1:0] ram_addr_o,
  output logic [3:0]        ram_we_o,
  output logic [31:0]       ram_wdata_o
);
  localparam int IDX_W  = RAM_AW - 1;
  localparam int IDX_HI = IDX_W + 1;
  localparam int TAG_LO = IDX_W + 2;
  localparam int TAG_W  = WIN_LSB - TAG_LO;

  logic             next_win, cur_win, tag_hit, lookup_hit;
  logic             fill, tag_we, tag_valid;
  logic [IDX_W-1:0] next_idx, cur_idx;
  logic [TAG_W-1:0] cur_tag;

  assign next_idx = addr_next_i[IDX_HI:2];
  assign cur_idx  = cpu_addr_i[IDX_HI:2];
  assign cur_tag  = cpu_addr_i[WIN_LSB-1:TAG_LO];

  cache_win_dec #(.ADDR_W(ADDR_W), .WIN_LSB(WIN_LSB)) u_next_win (
    .addr_i(addr_next_i), .in_win_o(next_win));
  cache_win_dec #(.ADDR_W(ADDR_W), .WIN_LSB(WIN_LSB)) u_cur_win (
    .addr_i(cpu_addr_i), .in_win_o(cur_win));

  cache_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk_i, .rst_ni,
    .rd_idx_i(cur_idx), .rd_tag_i(cur_tag), .rd_hit_o(tag_hit),
    .wr_en_i(tag_we), .wr_idx_i(cur_idx), .wr_tag_i(cur_tag), .wr_valid_i(tag_valid));

  assign lookup_hit = tag_hit && cur_win;

  cache_fsm u_fsm (
    .clk_i, .rst_ni,
    .next_win_i(next_win), .byte_we_next_i, .lookup_hit_i(lookup_hit), .mem_busy_i,
    .access_o(cache_access_o), .checking_o(cache_checking_o), .miss_o(cache_miss_o),
    .fill_o(fill), .tag_we_o(tag_we), .tag_valid_o(tag_valid));

  assign cache_hit_o = cache_checking_o && !cache_miss_o;

  // RAM port muxing: access from next address, fill from current address
  always_comb begin
    ram_en_o    = cache_access_o || fill;
    ram_addr_o  = {1'b1, next_idx};
    ram_we_o    = BE_NONE;
    ram_wdata_o = cpu_wdata_i;
    if (cache_access_o) begin
      ram_we_o = byte_we_next_i;
    end else if (fill) begin
      ram_addr_o  = {1'b1, cur_idx};
      ram_we_o    = BE_FULL;
      ram_wdata_o = mem_rdata_i;
    end
  end

  // R3
  access_then_check_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cache_access_o |=> cache_checking_o);

  // R11
  no_access_in_miss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cache_miss_o |-> !cache_access_o);

  // R5
  miss_no_recheck_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cache_miss_o |=> !cache_checking_o);

  // R6
  fill_no_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ram_en_o && !cache_access_o) |-> (ram_we_o == BE_FULL && !cache_miss_o));
endmodule

// File: tb/wt_cache_ctrl_tb_top.sv
`timescale 1ns/1ps
module wt_cache_ctrl_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:2] addr_next_i = '0;
  logic [3:0]  byte_we_next_i = '0;
  logic [31:2] cpu_addr_i = '0;
  logic [31:0] cpu_wdata_i = '0;
  logic [31:0] mem_rdata_i = '0;
  logic        mem_busy_i = 1'b0;
  logic        cache_access_o, cache_checking_o, cache_miss_o, cache_hit_o;
  logic        ram_en_o;
  logic [10:0] ram_addr_o;
  logic [3:0]  ram_we_o;
  logic [31:0] ram_wdata_o;

  always #4 clk_i = ~clk_i;

  wt_cache_ctrl dut_i (.*);

  int checks = 0, fails = 0;
  bit done = 0;

  // reference model state
  int          m_st = 0;          // 0 idle, 1 checking, 2 miss
  logic [3:0]  m_we = 4'h0;
  logic [31:2] m_cur = '0;
  bit          ref_vld [int];
  logic [8:0]  ref_tag [int];

  function automatic logic [31:2] wa(logic [31:0] b);
    return b[31:2];
  endfunction

  function automatic bit in_win(logic [31:2] a);
    return (a[31:28] == 4'h1) && (a[27:21] == 7'd0);
  endfunction

  task automatic chk(string rq, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", rq, what, act, exp, $time);
    end
  endtask

  task automatic step(logic [31:2] nxt, logic [3:0] we, logic busy,
                      logic [31:0] wd, logic [31:0] rd, string rq);
    int ix;
    bit match, e_chk, e_miss, e_hit, e_fill, e_acc, e_en, rdop;
    int nst;
    addr_next_i = nxt; byte_we_next_i = we; mem_busy_i = busy;
    cpu_addr_i = m_cur; cpu_wdata_i = wd; mem_rdata_i = rd;
    #1;
    ix     = int'(m_cur[11:2]);
    match  = ref_vld.exists(ix) && ref_vld[ix] && (ref_tag[ix] == m_cur[20:12]) && in_win(m_cur);
    rdop   = (m_we == 4'h0);
    e_chk  = (m_st == 1);
    e_miss = (e_chk && rdop && !match) || (m_st == 2 && busy);
    e_hit  = e_chk && !e_miss;
    e_fill = (m_st == 2) && !busy;
    e_acc  = in_win(nxt) && (m_st == 0 || (e_chk && !e_miss));
    e_en   = e_acc || e_fill;
    chk("R3", "checking", 32'(cache_checking_o), 32'(e_chk));
    chk(rq, "miss", 32'(cache_miss_o), 32'(e_miss));
    chk({rq, "/R4"}, "hit", 32'(cache_hit_o), 32'(e_hit));
    chk("R2/R3/R11", "access", 32'(cache_access_o), 32'(e_acc));
    chk("R3/R6", "ram_en", 32'(ram_en_o), 32'(e_en));
    if (e_en) begin
      chk("R1", "ram_addr", 32'(ram_addr_o),
          32'({1'b1, (e_acc ? nxt[11:2] : m_cur[11:2])}));
      chk("R3/R6", "ram_we", 32'(ram_we_o), 32'(e_acc ? we : 4'hF));
      chk("R6", "ram_wdata", ram_wdata_o, e_fill ? rd : wd);
    end else begin
      chk("R3", "ram_we idle", 32'(ram_we_o), 32'd0);
    end
    // model tag updates
    if (e_fill) begin
      ref_vld[ix] = 1'b1; ref_tag[ix] = m_cur[20:12];
    end else if (e_chk && !rdop) begin
      if (m_we == 4'hF) begin
        ref_vld[ix] = 1'b1; ref_tag[ix] = m_cur[20:12];
      end else if (!match) begin
        ref_vld[ix] = 1'b0;
      end
    end
    nst = e_acc ? 1 : (e_miss ? 2 : 0);
    @(posedge clk_i);
    m_st = nst;
    if (e_acc) m_we = we;
    if (!e_miss) m_cur = nxt;
    @(negedge clk_i);
  endtask

  localparam logic [31:0] IDLE_A = 32'h0000_0100;

  // lookup of one address with optional stall cycles
  task automatic lookup(logic [31:0] a, logic [3:0] we, logic [31:0] wd,
                        int nbusy, logic [31:0] rd, string rq);
    step(wa(a), we, 1'b0, wd, 32'h0, rq);
    step(wa(IDLE_A), 4'h0, 1'b0, 32'h0, 32'h0, rq);
    if (m_st == 2) begin
      for (int i = 0; i < nbusy; i++) step(wa(IDLE_A), 4'h0, 1'b1, 32'h0, 32'h0, rq);
      step(wa(IDLE_A), 4'h0, 1'b0, 32'h0, rd, rq);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] a, b, c, d;
    a = 32'h1000_0040; b = 32'h1000_1040; c = 32'h1000_0080; d = 32'h1000_1080;
    repeat (2) @(negedge clk_i);
    #1;
    // R8 reset state
    chk("R8", "reset checking", 32'(cache_checking_o), 32'd0);
    chk("R8", "reset miss", 32'(cache_miss_o), 32'd0);
    chk("R8", "reset ram_en", 32'(ram_en_o), 32'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    lookup(a, 4'h0, 32'h0, 2, 32'hA5A5_0001, "R8");    // cold miss, 2 busy cycles
    lookup(a, 4'h0, 32'h0, 0, 32'h0, "R7");             // hit after fill
    lookup(b, 4'h0, 32'h0, 1, 32'hB0B0_0002, "R5");    // conflict miss
    lookup(a, 4'h0, 32'h0, 0, 32'hA5A5_0003, "R5");    // evicted, miss without busy
    // pipelined hits: access during hit checking
    step(wa(a), 4'h0, 1'b0, 32'h0, 32'h0, "R7");
    step(wa(a), 4'h0, 1'b0, 32'h0, 32'h0, "R7");
    step(wa(a), 4'h0, 1'b0, 32'h0, 32'h0, "R7");
    step(wa(IDLE_A), 4'h0, 1'b0, 32'h0, 32'h0, "R7");
    // out-of-window addresses
    step(wa(32'h1020_0040), 4'h0, 1'b0, 32'h0, 32'h0, "R2");
    step(wa(32'h3000_0040), 4'h0, 1'b0, 32'h0, 32'h0, "R2");
    step(wa(32'h9000_0040), 4'h0, 1'b0, 32'h0, 32'h0, "R2");
    step(wa(IDLE_A), 4'h0, 1'b0, 32'h0, 32'h0, "R2");
    // full-word store installs tag
    lookup(c, 4'hF, 32'hC0DE_0004, 0, 32'h0, "R9");
    lookup(c, 4'h0, 32'h0, 0, 32'h0, "R9");
    // partial store, other tag, same index: invalidates
    lookup(d, 4'h3, 32'h0D0D_0005, 0, 32'h0, "R10");
    lookup(c, 4'h0, 32'h0, 1, 32'hC0DE_0006, "R10");
    // partial store, own tag: stays valid
    lookup(a, 4'hC, 32'h1234_0007, 0, 32'h0, "R10");
    lookup(a, 4'h0, 32'h0, 0, 32'h0, "R10");
    // miss with in-window next address: no new access (R11)
    step(wa(b), 4'h0, 1'b0, 32'h0, 32'h0, "R11");
    step(wa(a), 4'h0, 1'b0, 32'h0, 32'h0, "R11");
    step(wa(a), 4'h0, 1'b1, 32'h0, 32'h0, "R11");
    step(wa(a), 4'h0, 1'b0, 32'hFFFF_0000, 32'hB0B0_0008, "R11");
    lookup(b, 4'h0, 32'h0, 0, 32'h0, "R7");
    step(wa(IDLE_A), 4'h0, 1'b0, 32'h0, 32'h0, "R3");

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule